// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Per-Bit Write Masking

This block sits between a clocked request source and an asynchronous static RAM of 1,048,576 eight-bit words. That RAM has separate input and output data pins, one active-low select line shared by every bit, and eight active-low write strobes, each tied to a single data bit. A requester offers one read or one write at a time on a valid/ready handshake. The controller holds address and data on the RAM pins and produces the select and write-strobe pulses. It returns read data as a single-cycle response.

Each write carries an eight-bit mask. Only the strobes of bits whose mask bit is set are pulsed, so the other bits of the addressed word keep their contents. The controller needs no read-modify-write cycle for this. The RAM's minimum times are given in nanoseconds: write overlap, data setup before the end of the write, access delay, cycle length, and the delay before the outputs drive again after a write. Each of these becomes a cycle count, worked out at elaboration from a clock-period parameter.

Top module: `asram_bitmask_ctrl`

## Requirements
- R1: While reset is held and after it is released, the select line is high, all eight write strobes are high, the request side is ready and no response is flagged.
- R2: For an accepted write, strobe bit i (sramWeN[i]) goes low exactly when mask bit i (reqMask[i]) is 1. Each strobe that goes low stays low for WP = max(ceil(12/P), ceil(7/P), 1) consecutive cycles, where P is CLK_PERIOD_NS. No strobe is ever low while the select line is high.
- R3: While the select line is low, neither the RAM address nor the RAM input data changes. Both are loaded only when a request is accepted.
- R4: A write whose mask is all zero drives no strobe low, still occupies the full write time, and leaves the stored word unchanged.
- R5: A read drives the select line low with every strobe high and samples the RAM output after RD cycles. RD is ceil(15/P) when the previous accepted request was a read. The response data equals the stored word.
- R6: When the previous accepted request was a write, a read instead waits RAW = max(ceil((5+15)/P), ceil(15/P)) cycles before sampling. The sampled data includes the bits just written.
- R7: Every read yields exactly one single-cycle rspValid pulse, and responses arrive in request order. Writes yield no response.
- R8: reqReady falls in the cycle after acceptance and stays low for the whole operation. That is WP + REC cycles for a write, where REC = max(ceil(15/P) - WP, 1), and RD or RAW cycles for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle and able to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 20 | Word address |
| reqWdata | input | 8 | Write data |
| reqMask | input | 8 | Per-bit write mask, 1 = write that bit |
| rspValid | output | 1 | Read data valid, one cycle |
| rspData | output | 8 | Read data |
| sramAddr | output | 20 | RAM address pins |
| sramD | output | 8 | RAM data-in pins |
| sramQ | input | 8 | RAM data-out pins |
| sramCeN | output | 1 | RAM select, active low |
| sramWeN | output | 8 | RAM per-bit write strobes, active low |

## Verification
If the wait counter stops short, the RAM model shows it within the read. The model returns a garbage value until the access time has elapsed, so the response mismatches on the very next rspValid pulse. If the mask register or the strobe decode is wrong, the wrong bits change. That surfaces either as a strobe set that differs from the mask, seen at the select line's rising edge, or as wrong data on the next read of that address. If the state machine lingers or returns early, the ready pin shows a busy length that differs from the expected count, and this is visible as soon as the operation ends.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_WREC  = 2'd2,
    ST_READ  = 2'd3
  } ctrlState_e;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic load;     // latch request fields into the pin registers
    logic ce;       // select the RAM
    logic we;       // pulse write strobes (gated by mask in the datapath)
    logic capture;  // sample RAM output into the response register
  } strobe_t;

  // Cycles needed to cover a nanosecond minimum; at least one when nonzero.
  function automatic int cyclesFor(input int ns, input int periodNs);
    int c;
    if (ns <= 0) return 0;
    c = (ns + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_CYCLE_NS    = 15,
  parameter int T_WPULSE_NS   = 12,
  parameter int T_DSETUP_NS   = 7,
  parameter int T_ACCESS_NS   = 15,
  parameter int T_OUTON_NS    = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strb
);

  localparam int CYC_CYC = cyclesFor(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int WP_CYC  = maxOf(maxOf(cyclesFor(T_WPULSE_NS, CLK_PERIOD_NS),
                                       cyclesFor(T_DSETUP_NS, CLK_PERIOD_NS)), 1);
  localparam int REC_CYC = (CYC_CYC > WP_CYC) ? (CYC_CYC - WP_CYC) : 1;
  localparam int RD_CYC  = maxOf(cyclesFor(T_ACCESS_NS, CLK_PERIOD_NS), 1);
  localparam int RAW_CYC = maxOf(cyclesFor(T_OUTON_NS + T_ACCESS_NS, CLK_PERIOD_NS), RD_CYC);
  localparam int MAX_CYC = maxOf(maxOf(WP_CYC, REC_CYC), RAW_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] RAW_LAST = CNT_W'(RAW_CYC - 1);

  ctrlState_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rdLast;
  logic             lastWrite;
  logic             ceR;
  logic             weR;
  logic             accept;
  logic             cntDone;

  always_comb begin
    reqReady     = (state == ST_IDLE);
    accept       = reqValid && reqReady;
    cntDone      = 1'b0;
    unique case (state)
      ST_WRITE: cntDone = (cnt == WP_LAST);
      ST_WREC:  cntDone = (cnt == REC_LAST);
      ST_READ:  cntDone = (cnt == rdLast);
      default:  cntDone = 1'b0;
    endcase
    strb.load    = accept;
    strb.ce      = ceR;
    strb.we      = weR;
    strb.capture = (state == ST_READ) && cntDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      rdLast    <= RD_LAST;
      lastWrite <= 1'b0;
      ceR       <= 1'b0;
      weR       <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (accept) begin
            ceR       <= 1'b1;
            lastWrite <= reqWrite;
            if (reqWrite) begin
              weR   <= 1'b1;
              state <= ST_WRITE;
            end else begin
              rdLast <= lastWrite ? RAW_LAST : RD_LAST;
              state  <= ST_READ;
            end
          end
        end
        ST_WRITE: begin
          if (cntDone) begin
            ceR   <= 1'b0;
            weR   <= 1'b0;
            cnt   <= '0;
            state <= ST_WREC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WREC: begin
          if (cntDone) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_READ: begin
          if (cntDone) begin
            ceR   <= 1'b0;
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] reqMask,
  input  logic [DATA_W-1:0] sramQ,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramD,
  output logic              sramCeN,
  output logic [DATA_W-1:0] sramWeN,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] addrR;
  logic [DATA_W-1:0] dataR;
  logic [DATA_W-1:0] maskR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR    <= '0;
      dataR    <= '0;
      maskR    <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strb.load) begin
        addrR <= reqAddr;
        dataR <= reqWdata;
        maskR <= reqMask;
      end
      rspValid <= strb.capture;
      if (strb.capture) rspData <= sramQ;
    end
  end

  assign sramAddr = addrR;
  assign sramD    = dataR;
  assign sramCeN  = ~strb.ce;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bitStrobe
    assign sramWeN[b] = ~(maskR[b] & strb.we);
  end

endmodule

// File: rtl/asram_bitmask_ctrl.sv
module asram_bitmask_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] reqMask,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramD,
  input  logic [DATA_W-1:0] sramQ,
  output logic              sramCeN,
  output logic [DATA_W-1:0] sramWeN
);

  strobe_t strb;

  asram_ctrl #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  asram_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .sramQ   (sramQ),
    .sramAddr(sramAddr),
    .sramD   (sramD),
    .sramCeN (sramCeN),
    .sramWeN (sramWeN),
    .rspValid(rspValid),
    .rspData (rspData)
  );

endmodule

// File: rtl/asram_checker.sv
module asram_checker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] sramAddr,
  input logic [DATA_W-1:0] sramD,
  input logic              sramCeN,
  input logic [DATA_W-1:0] sramWeN
);

  AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (sramWeN != '1) |-> !sramCeN); // R2

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr)); // R3

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramD)); // R3

  AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    !sramCeN |-> !reqReady); // R8

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R7

  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($past(!sramCeN) && $past(sramWeN == '1))); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (sramCeN && sramWeN == '1 && !rspValid)); // R1

endmodule

bind asram_bitmask_ctrl asram_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_asramChecker (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .rspValid(rspValid),
  .sramAddr(sramAddr),
  .sramD   (sramD),
  .sramCeN (sramCeN),
  .sramWeN (sramWeN)
);

// File: tb/test_asram_bitmask_ctrl.sv
`timescale 1ns/1ps
module test_asram_bitmask_ctrl;

  localparam int PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 8;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + PERIOD - 1) / PERIOD;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int WP  = (cdiv(12) > cdiv(7)) ? cdiv(12) : cdiv(7);
  localparam int CYC = cdiv(15);
  localparam int REC = (CYC > WP) ? CYC - WP : 1;
  localparam int RD  = cdiv(15);
  localparam int RAW = (cdiv(20) > RD) ? cdiv(20) : RD;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [DW-1:0] reqMask = '0;
  logic          rspValid;
  logic [DW-1:0] rspData;
  logic [AW-1:0] sramAddr;
  logic [DW-1:0] sramD;
  logic [DW-1:0] sramQ = 8'h5A;
  logic          sramCeN;
  logic [DW-1:0] sramWeN;

  asram_bitmask_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PERIOD)) i_asram_bitmask_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(rspValid), .rspData(rspData), .sramAddr(sramAddr), .sramD(sramD),
    .sramQ(sramQ), .sramCeN(sramCeN), .sramWeN(sramWeN)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int nReads = 0;
  int nRsps = 0;
  logic prevWrite = 1'b0;

  logic [DW-1:0] mem [int];
  logic [DW-1:0] golden [int];
  logic [DW-1:0] expQ [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] memGet(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  function automatic logic [DW-1:0] goldGet(input int a);
    return golden.exists(a) ? golden[a] : 8'h00;
  endfunction

  // RAM model and response monitor
  int            ceLowCnt = 0;
  logic          prevCeN = 1'b1;
  logic          opHadWe = 1'b0;
  logic          wasWrite = 1'b0;
  logic [DW-1:0] opStrobes = '0;
  logic [DW-1:0] lastOpStrobes = '0;
  int            weCnt [DW];
  logic [AW-1:0] weAddr [DW];
  logic          weData [DW];

  always @(negedge clk) begin
    if (!rstN) begin
      ceLowCnt = 0; prevCeN = 1'b1; opHadWe = 1'b0; wasWrite = 1'b0;
      for (int i = 0; i < DW; i++) weCnt[i] = 0;
      sramQ = 8'h5A;
    end else begin
      if (!sramCeN && prevCeN) begin opHadWe = 1'b0; opStrobes = '0; end
      if (sramCeN && !prevCeN) begin wasWrite = opHadWe; lastOpStrobes = opStrobes; end
      ceLowCnt = sramCeN ? 0 : ceLowCnt + 1;
      if (sramCeN && sramWeN != 8'hFF) check(0, "R2 strobe without select", sramWeN, 8'hFF);
      for (int i = 0; i < DW; i++) begin
        if (!sramWeN[i]) begin
          opHadWe = 1'b1;
          opStrobes[i] = 1'b1;
          if (weCnt[i] > 0) begin
            if (weAddr[i] != sramAddr) check(0, "R3 addr moved in pulse", sramAddr, weAddr[i]);
            if (weData[i] != sramD[i]) check(0, "R3 data moved in pulse", sramD[i], weData[i]);
          end
          weAddr[i] = sramAddr;
          weData[i] = sramD[i];
          weCnt[i]++;
        end else if (weCnt[i] > 0) begin
          logic [DW-1:0] t;
          check(weCnt[i] == WP, "R2 pulse width", weCnt[i], WP);
          t = memGet(int'(weAddr[i]));
          t[i] = weData[i];
          mem[int'(weAddr[i])] = t;
          weCnt[i] = 0;
        end
      end
      sramQ = (!sramCeN && sramWeN == 8'hFF && ceLowCnt >= (wasWrite ? RAW : RD))
              ? memGet(int'(sramAddr)) : 8'h5A;
      if (rspValid) begin
        nRsps++;
        if (expQ.size() == 0) check(0, "R7 unexpected response", rspData, 0);
        else begin
          logic [DW-1:0] e;
          e = expQ.pop_front();
          check(rspData == e, "R5/R6 read data", rspData, e);
        end
      end
      prevCeN = sramCeN;
    end
  end

  task automatic issue(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [DW-1:0] m, input int expBusy);
    int busy;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d; reqMask = m;
    @(negedge clk);
    reqValid = 1'b0;
    busy = 0;
    while (!reqReady) begin busy++; @(negedge clk); end
    check(busy == expBusy, "R8 busy length", busy, expBusy);
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [DW-1:0] m);
    logic [DW-1:0] g;
    issue(1'b1, a, d, m, WP + REC);
    g = goldGet(int'(a));
    golden[int'(a)] = (g & ~m) | (d & m);
    if (m == 8'h00) check(lastOpStrobes == 8'h00, "R4 zero mask strobes", lastOpStrobes, 0);
    else check(lastOpStrobes == m, "R2 strobed bits", lastOpStrobes, m);
    prevWrite = 1'b1;
  endtask

  task automatic doRead(input logic [AW-1:0] a);
    expQ.push_back(goldGet(int'(a)));
    nReads++;
    issue(1'b0, a, 8'h00, 8'h00, prevWrite ? RAW : RD); // R6 when after write
    prevWrite = 1'b0;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sramCeN == 1'b1, "R1 select high in reset", sramCeN, 1);
    check(sramWeN == 8'hFF, "R1 strobes high in reset", sramWeN, 8'hFF);
    check(rspValid == 1'b0, "R1 no response in reset", rspValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);
    check(sramCeN == 1'b1 && sramWeN == 8'hFF, "R1 idle pins", sramWeN, 8'hFF);

    doWrite(20'h00001, 8'hA5, 8'hFF);
    doRead(20'h00001);                       // R6 read right after write
    doRead(20'hFFFFF);                       // R5 top address, never written
    doWrite(20'hFFFFF, 8'h3C, 8'hFF);
    doRead(20'hFFFFF);
    doWrite(20'h00000, 8'hFF, 8'h0F);        // R2 low nibble only
    doRead(20'h00000);
    doWrite(20'h00000, 8'h00, 8'h81);        // R2 clears bit 0, bit 7 already 0
    doRead(20'h00000);
    doWrite(20'h00000, 8'h55, 8'h00);        // R4 nothing written
    doRead(20'h00000);
    for (int i = 0; i < DW; i++) doWrite(20'h12345, 8'hFF, 8'(1 << i));
    doRead(20'h12345);
    doWrite(20'h12345, 8'h00, 8'hAA);
    doRead(20'h12345);
    doRead(20'h00001);                       // R5 back-to-back reads
    doRead(20'h00000);
    doRead(20'hFFFFF);

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R7 all responses returned", expQ.size(), 0);
    check(nRsps == nReads, "R7 one response per read", nRsps, nReads);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule